// File: doc/BRIEF.md
# Flash Access Protection Checker

This block sits between bus requesters and a two-bank flash array and decides, request by request, whether the access may go ahead. Each request carries an address, a target space, an access kind, the requester's identity and a flag that says whether the chip is in an external context: a debugger is attached, or the chip booted from RAM or from its loader. The checker compares these against the readout protection level, two write-locked page ranges per bank and one execute-only double-word range per bank. All protection settings arrive as plain configuration inputs.

A granted request is forwarded to the array in the same cycle through `arr_en`. One cycle later the checker returns a response that carries grant or deny, an error pulse on deny, and read data. The read data is the array's data on a granted read or fetch and all zeros in every other case. Each bank has 256 pages of 2 Kbyte. The main-space address is {bank, page, byte offset}, and execute-only bounds count 8-byte double words within a bank.

Top module: `flash_guard`

## Requirements
- R1: Every request accepted in cycle N gives `resp_valid` in cycle N+1. `arr_en` is high in cycle N exactly when the request is granted. A denied response has `resp_err` high for that one cycle and `resp_rdata` all zeros. A granted read (`req_kind` 0 = instruction fetch, 1 = data read) returns `arr_rdata`. A granted write (2) or erase (3) returns zeros.
- R2: At protection level 0 (`rdp_level` 0), no request is refused for readout reasons. Only the range rules R8 to R10 apply.
- R3: At level 1, a main-space (`req_space` 0) request in external context is denied. External context means `ext_ctx` is high or `req_src` is 2 (debug).
- R4: At level 2 (`rdp_level` 2 or 3), every request in external context is denied, whatever its space.
- R5: System memory (`req_space` 1) denies writes and erases in every context. It allows fetches and reads, including in external context at level 1.
- R6: Option space (`req_space` 2) allows every access kind at levels 0 and 1, in any context. At level 2 it allows only fetches and reads.
- R7: Backup/SRAM2 space (`req_space` 3) denies erase. It denies any access in external context at level 1. Otherwise it allows the access.
- R8: A main-space write whose page lies inside either enabled write-locked range of its own bank (first page <= page <= last page) is denied.
- R9: A main-space access whose double word lies inside its bank's enabled execute-only range is granted only when it is an instruction fetch from the CPU (`req_src` 0). DMA (`req_src` 1) and debug are denied.
- R10: A main-space page erase is denied as a whole if its page is inside an enabled write-locked range, or if its page holds any double word of the bank's enabled execute-only range.
- R11: A range whose first bound is greater than its last bound is disabled and protects nothing.
- R12: The ranges of one bank (`req_addr` MSB) have no effect on requests to the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 20 | {bank, page, byte offset} |
| req_space | input | 2 | 0 main, 1 system, 2 option, 3 backup/SRAM2 |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 erase |
| req_src | input | 2 | 0 CPU, 1 DMA, 2 debug |
| ext_ctx | input | 1 | Debug attached or boot from RAM/loader |
| rdp_level | input | 2 | Readout protection level |
| wp_first | input | 4x8 | Write-lock first page, index bank*2+area |
| wp_last | input | 4x8 | Write-lock last page, index bank*2+area |
| xo_first | input | 2x16 | Execute-only first double word per bank |
| xo_last | input | 2x16 | Execute-only last double word per bank |
| arr_en | output | 1 | Forward granted request to the array |
| arr_rdata | input | 64 | Array read data, one cycle after `arr_en` |
| resp_valid | output | 1 | Response present |
| resp_grant | output | 1 | Request was allowed |
| resp_err | output | 1 | Request was denied |
| resp_rdata | output | 64 | Read data, zero unless a granted read |

## Verification
`arr_en` is combinational, so the bench samples it one nanosecond after it drives a request, inside the same cycle. The response fields are due one register later. The bench samples them at the falling edge that follows the next rising edge, and it drops `req_valid` at that same point so that each response is matched to exactly one request. It sweeps every level, context, requester, kind and space over addresses that sit inside, next to and outside each range, including a reversed range and a bank-mirrored page. A bench model built from the rules above computes the expected grant and data.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int PAGE_BITS = 8,
  parameter int OFF_BITS  = 11,
  parameter int DATA_W    = 64,
  parameter int WP_AREAS  = 2,
  localparam int ADDR_W   = 1 + PAGE_BITS + OFF_BITS,
  localparam int DW_BITS  = PAGE_BITS + OFF_BITS - 3
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [1:0]                               req_space,
  input  logic [1:0]                               req_kind,
  input  logic [1:0]                               req_src,
  input  logic                                     ext_ctx,
  input  logic [1:0]                               rdp_level,
  input  logic [2*WP_AREAS-1:0][PAGE_BITS-1:0]     wp_first,
  input  logic [2*WP_AREAS-1:0][PAGE_BITS-1:0]     wp_last,
  input  logic [1:0][DW_BITS-1:0]                  xo_first,
  input  logic [1:0][DW_BITS-1:0]                  xo_last,
  output logic                                     arr_en,
  input  logic [DATA_W-1:0]                        arr_rdata,
  output logic                                     resp_valid,
  output logic                                     resp_grant,
  output logic                                     resp_err,
  output logic [DATA_W-1:0]                        resp_rdata
);
  logic                 bank;
  logic [PAGE_BITS-1:0] page;
  logic [DW_BITS-1:0]   dword;
  logic [DW_BITS-1:0]   xo_lo, xo_hi;
  logic                 xo_on, in_xo, xo_page, wp_hit;
  logic                 is_fetch, is_rd, is_wr, is_er, is_cpu, ext;
  logic                 lvl1, lvl2;
  logic                 main_ok, space_ok, allow;
  logic                 has_data;

  assign bank  = req_addr[ADDR_W-1];
  assign page  = req_addr[ADDR_W-2:OFF_BITS];
  assign dword = req_addr[ADDR_W-2:3];

  assign xo_lo   = xo_first[bank];
  assign xo_hi   = xo_last[bank];
  assign xo_on   = xo_lo <= xo_hi;
  assign in_xo   = xo_on && dword >= xo_lo && dword <= xo_hi;
  assign xo_page = xo_on && page >= xo_lo[DW_BITS-1:OFF_BITS-3]
                         && page <= xo_hi[DW_BITS-1:OFF_BITS-3];

  always_comb begin
    wp_hit = 1'b0;
    for (int a = 0; a < WP_AREAS; a++) begin
      if (wp_first[int'(bank)*WP_AREAS+a] <= wp_last[int'(bank)*WP_AREAS+a] &&
          page >= wp_first[int'(bank)*WP_AREAS+a] &&
          page <= wp_last[int'(bank)*WP_AREAS+a])
        wp_hit = 1'b1;
    end
  end

  assign is_fetch = req_kind == 2'd0;
  assign is_rd    = req_kind <= 2'd1;
  assign is_wr    = req_kind == 2'd2;
  assign is_er    = req_kind == 2'd3;
  assign is_cpu   = req_src == 2'd0;
  assign ext      = ext_ctx || req_src == 2'd2;
  assign lvl1     = rdp_level == 2'd1;
  assign lvl2     = rdp_level[1];

  assign main_ok = !(lvl1 && ext) &&
                   (is_er ? !(wp_hit || xo_page) :
                    in_xo ? (is_fetch && is_cpu) :
                            !(is_wr && wp_hit));

  always_comb begin
    case (req_space)
      2'd0:    space_ok = main_ok;
      2'd1:    space_ok = is_rd;
      2'd2:    space_ok = !lvl2 || is_rd;
      default: space_ok = !is_er && !(lvl1 && ext);
    endcase
  end

  assign allow  = space_ok && !(lvl2 && ext);
  assign arr_en = req_valid && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      has_data   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= arr_en;
      has_data   <= arr_en && is_rd;
    end
  end

  assign resp_err   = resp_valid && !resp_grant;
  assign resp_rdata = has_data ? arr_rdata : '0;

  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_err_marks_deny_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> $past(req_valid && !arr_en));
  assert_deny_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_grant) |-> resp_rdata == '0);
  assert_lvl2_ext_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rdp_level[1] && (ext_ctx || req_src == 2'd2)) |-> !arr_en);
  assert_sys_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd1 && req_kind[1]) |-> !arr_en);
  assert_xo_cpu_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd0 && in_xo && arr_en) |-> (req_kind == 2'd0 && req_src == 2'd0));
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [19:0] req_addr = '0;
  logic [1:0] req_space = '0, req_kind = '0, req_src = '0, rdp_level = '0;
  logic ext_ctx = 0;
  logic [3:0][7:0] wp_first, wp_last;
  logic [1:0][15:0] xo_first, xo_last;
  logic arr_en, resp_valid, resp_grant, resp_err;
  logic [63:0] arr_rdata = 64'hA5C3_0F1E_9876_5432;
  logic [63:0] resp_rdata;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [19:0] addrs [8];

  always #2 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_space(req_space), .req_kind(req_kind), .req_src(req_src),
    .ext_ctx(ext_ctx), .rdp_level(rdp_level), .wp_first(wp_first),
    .wp_last(wp_last), .xo_first(xo_first), .xo_last(xo_last),
    .arr_en(arr_en), .arr_rdata(arr_rdata), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .resp_err(resp_err), .resp_rdata(resp_rdata));

  function automatic bit in_rng(int v, int lo, int hi);
    return lo <= hi && v >= lo && v <= hi;
  endfunction

  function automatic bit model(int lv, bit e, int s, int k, int sp,
                               logic [19:0] a, output string tag);
    bit x = e || s == 2;
    int b = a[19];
    int pg = a[18:11];
    int dw = a[18:3];
    bit wph, xin, xpg;
    if (lv >= 2 && x) begin tag = "R4"; return 0; end
    if (sp == 1) begin tag = "R5"; return k <= 1; end
    if (sp == 2) begin tag = "R6"; return lv < 2 || k <= 1; end
    if (sp == 3) begin tag = "R7"; return k != 3 && !(lv == 1 && x); end
    if (lv == 1 && x) begin tag = "R3"; return 0; end
    wph = in_rng(pg, wp_first[2*b], wp_last[2*b]) || in_rng(pg, wp_first[2*b+1], wp_last[2*b+1]);
    xin = in_rng(dw, xo_first[b], xo_last[b]);
    xpg = xo_first[b] <= xo_last[b] && in_rng(pg, xo_first[b] / 256, xo_last[b] / 256);
    if (k == 3) begin tag = "R10"; return !(wph || xpg); end
    if (xin) begin tag = "R9"; return k == 0 && s == 0; end
    if (k == 2 && wph) begin tag = "R8"; return 0; end
    tag = "R2";
    return 1;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(int lv, bit e, int s, int k, int sp, int ai);
    string tag;
    bit g;
    logic [63:0] ed;
    g = model(lv, e, s, k, sp, addrs[ai], tag);
    if (ai == 6) tag = {tag, " R11"};
    if (ai == 4) tag = {tag, " R12"};
    ed = (g && k <= 1) ? arr_rdata : 64'd0;
    @(negedge clk);
    rdp_level = 2'(lv); ext_ctx = e; req_src = 2'(s); req_kind = 2'(k);
    req_space = 2'(sp); req_addr = addrs[ai]; req_valid = 1;
    #1;
    chk(arr_en == g, {tag, " R1 arr_en"}, 64'(arr_en), 64'(g));
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid && resp_grant == g && resp_err == !g,
        {tag, " R1 grant"}, {resp_valid, resp_grant, resp_err}, {1'b1, g, !g});
    chk(resp_rdata == ed, {tag, " R1 rdata"}, resp_rdata, ed);
  endtask

  initial begin
    wp_first[0] = 10;  wp_last[0] = 12;
    wp_first[1] = 200; wp_last[1] = 200;
    wp_first[2] = 50;  wp_last[2] = 60;
    wp_first[3] = 9;   wp_last[3] = 3;
    xo_first[0] = 1000; xo_last[0] = 1100;
    xo_first[1] = 5000; xo_last[1] = 5000;
    addrs[0] = {1'b0, 8'd10, 11'd0};
    addrs[1] = {1'b0, 19'(1000 * 8)};
    addrs[2] = {1'b0, 19'(999 * 8)};
    addrs[3] = {1'b0, 8'd100, 11'd40};
    addrs[4] = {1'b1, 8'd10, 11'd0};
    addrs[5] = {1'b1, 19'(5000 * 8)};
    addrs[6] = {1'b1, 8'd5, 11'd8};
    addrs[7] = {1'b0, 8'd200, 11'd2047};
    repeat (3) @(negedge clk);
    chk(!resp_valid && !resp_err && resp_rdata == 0, "R1 reset", {resp_valid, resp_err}, 0);
    rst_n = 1;
    for (int lv = 0; lv < 3; lv++)
      for (int e = 0; e < 2; e++)
        for (int s = 0; s < 3; s++)
          for (int k = 0; k < 4; k++)
            for (int sp = 0; sp < 4; sp++)
              for (int ai = 0; ai < 8; ai++)
                if (sp == 0 || ai == 3) run(lv, e[0], s, k, sp, ai);
    run(3, 1, 0, 1, 2, 3);
    run(3, 0, 0, 2, 2, 3);
    @(negedge clk);
    chk(!resp_valid && !resp_err, "R1 idle", {resp_valid, resp_err}, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule